// File: doc/BRIEF.md
# MSI snooping line controller

This block keeps coherence for a small private write-back cache that shares a snooping bus with other caches. It holds a direct-mapped set of lines, each one Invalid, Shared or Modified, with a tag and one data word per line. The processor side issues read, write and evict requests one at a time. The controller answers hits locally. It issues a bus transaction for each miss, upgrade or dirty eviction, and it waits for a grant that completes the transaction.

On the snoop side the controller watches the transactions of the other caches. A dirty copy answers with a data flush. A clean copy is dropped silently when another cache wants to write. Only a Modified holder ever puts data on the bus, and an upgrade from Shared to Modified carries no data. The controller keeps at most one request outstanding. While that request waits for its grant, snoops are still serviced. The pending command is chosen again from the line's current state in every cycle, so a line that is invalidated under a waiting upgrade asks for a full read-for-ownership.

Top module: `msi_line_ctrl`

## Requirements
- R1: A read whose line is not present and whose slot is not dirty raises bus_req with command BusRd (code 0) and the line address. At the grant, the word on bus_rdata is returned as cpu_rdata and the line becomes Shared.
- R2: A write whose line is not present and whose slot is not dirty issues BusRdX (code 1). At the grant, the line becomes Modified and holds the write data.
- R3: A write to a Shared line issues BusUpgr (code 2). The grant carries no data, and the line becomes Modified with the write data.
- R4: A read of a Shared or Modified line, or a write to a Modified line, raises no bus request. cpu_done pulses on the second falling edge after the request is presented, and a read returns the stored word.
- R5: A Shared line that snoops BusRdX or BusUpgr becomes Invalid and raises no flush.
- R6: A Modified line that snoops BusRd drives flush_valid with its word in the cycle after the snoop and becomes Shared.
- R7: A Modified line that snoops BusRdX flushes its word in the same way and becomes Invalid.
- R8: Evicting a Modified line issues BusWB (code 3) with its word and address. Evicting a Shared line issues nothing and leaves the line Invalid. Evicting an address that is not present changes nothing.
- R9: The index is address bits [OFS_W +: IDX_W] and the tag is the bits above them. A miss whose slot holds a different Modified line first writes that line back with BusWB and then fetches. A different Shared line is replaced with no write-back.
- R10: Only one bus request is outstanding. It stays raised until granted, and cpu_ready is low while it waits. Snoops are serviced during the wait, and a pending upgrade whose line has been invalidated becomes BusRdX.
- R11: A snoop to an index whose line is Invalid, or whose tag differs, raises no flush and leaves the resident line unchanged.
- R12: Processor operations are encoded read 0, write 1 and evict 2. A request is accepted only while cpu_ready is high, and flush_valid appears only in the cycle after a snooped BusRd or BusRdX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request strobe |
| cpu_op | input | 2 | Operation: 0 read, 1 write, 2 evict |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 BusRd, 1 BusRdX, 2 BusUpgr, 3 BusWB |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Grant that completes the transaction |
| bus_rdata | input | DATA_W | Fill data, valid with bus_gnt |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_line | input | ADDR_W-OFS_W | Snooped line address (index in the low bits) |
| flush_valid | output | 1 | Dirty data supplied in reply to a snoop |
| flush_data | output | DATA_W | Flushed word |

## Verification
A wrong line state is never visible directly. It shows up at the next access to that line. A line left Shared when it should be Invalid answers a read with no bus request two cycles later, where BusRd was expected. A line left Modified when it should be Shared answers a later write silently, where BusUpgr was expected. A lost dirty state shows as a missing flush in the cycle after a snoop, or as a missing BusWB at the first conflicting miss. The bench therefore follows every snoop and every eviction with a processor access that exposes the state through the bus command it produces.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic [1:0]              cpu_op,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic                    cpu_done,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    bus_req,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_gnt,
  input  logic [DATA_W-1:0]       bus_rdata,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-OFS_W-1:0] snp_line,
  output logic                    flush_valid,
  output logic [DATA_W-1:0]       flush_data
);
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2;
  localparam logic [1:0] B_RD = 2'd0, B_RDX = 2'd1, B_UPG = 2'd2, B_WB = 2'd3;

  logic [1:0]        st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic              act_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tg;
  logic [1:0]       cur;
  logic             hit;
  logic             need;
  logic [1:0]       cmd;
  logic             final_tx;
  logic             go;
  logic             complete;

  assign idx = addr_q[OFS_W +: IDX_W];
  assign tg  = addr_q[ADDR_W-1 -: TAG_W];
  assign cur = st_q[idx];
  assign hit = (cur != ST_I) && (tag_q[idx] == tg);

  always_comb begin
    need = 1'b0;
    cmd  = B_RD;
    case (op_q)
      OP_RD: begin
        if (!hit) begin
          need = 1'b1;
          cmd  = (cur == ST_M) ? B_WB : B_RD;
        end
      end
      OP_WR: begin
        if (hit && cur == ST_S) begin
          need = 1'b1;
          cmd  = B_UPG;
        end else if (!hit) begin
          need = 1'b1;
          cmd  = (cur == ST_M) ? B_WB : B_RDX;
        end
      end
      OP_EV: begin
        if (hit && cur == ST_M) begin
          need = 1'b1;
          cmd  = B_WB;
        end
      end
      default: ;
    endcase
  end

  assign final_tx  = (op_q == OP_EV) || (cmd != B_WB);
  assign go        = act_q && !snp_valid;
  assign complete  = go && (!need || (bus_gnt && final_tx));

  assign cpu_ready = !act_q;
  assign bus_req   = act_q && need;
  assign bus_cmd   = cmd;
  assign bus_addr  = (cmd == B_WB) ? {tag_q[idx], idx, {OFS_W{1'b0}}} : addr_q;
  assign bus_wdata = dat_q[idx];

  logic [IDX_W-1:0] sidx;
  logic [TAG_W-1:0] stag;
  logic             s_hit;
  logic [1:0]       s_st;

  assign sidx  = snp_line[IDX_W-1:0];
  assign stag  = snp_line[LINE_W-1 -: TAG_W];
  assign s_st  = st_q[sidx];
  assign s_hit = snp_valid && (s_st != ST_I) && (tag_q[sidx] == stag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
      act_q       <= 1'b0;
      op_q        <= OP_RD;
      addr_q      <= '0;
      wd_q        <= '0;
      cpu_done    <= 1'b0;
      cpu_rdata   <= '0;
      flush_valid <= 1'b0;
      flush_data  <= '0;
    end else begin
      cpu_done    <= 1'b0;
      flush_valid <= 1'b0;

      if (!act_q && cpu_req) begin
        act_q  <= 1'b1;
        op_q   <= cpu_op;
        addr_q <= cpu_addr;
        wd_q   <= cpu_wdata;
      end

      if (s_hit) begin
        if (s_st == ST_M && (snp_cmd == B_RD || snp_cmd == B_RDX)) begin
          flush_valid <= 1'b1;
          flush_data  <= dat_q[sidx];
          st_q[sidx]  <= (snp_cmd == B_RD) ? ST_S : ST_I;
        end else if (s_st == ST_S && (snp_cmd == B_RDX || snp_cmd == B_UPG)) begin
          st_q[sidx] <= ST_I;
        end
      end else if (go) begin
        if (need && bus_gnt) begin
          case (cmd)
            B_RD: begin
              st_q[idx]  <= ST_S;
              tag_q[idx] <= tg;
              dat_q[idx] <= bus_rdata;
            end
            B_RDX: begin
              st_q[idx]  <= ST_M;
              tag_q[idx] <= tg;
              dat_q[idx] <= wd_q;
            end
            B_UPG: begin
              st_q[idx]  <= ST_M;
              dat_q[idx] <= wd_q;
            end
            default: st_q[idx] <= ST_I;
          endcase
        end else if (!need) begin
          if (op_q == OP_WR) dat_q[idx] <= wd_q;
          if (op_q == OP_EV && hit) st_q[idx] <= ST_I;
        end
      end

      if (complete) begin
        act_q     <= 1'b0;
        cpu_done  <= 1'b1;
        cpu_rdata <= (need && cmd == B_RD) ? bus_rdata : dat_q[idx];
      end
    end
  end
endmodule

module msi_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ready,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       flush_valid
);
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> bus_req); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> bus_req); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ready); // R10
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> ($past(snp_valid) && ($past(snp_cmd) == 2'd0 || $past(snp_cmd) == 2'd1))); // R12
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_ready); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R12
endmodule

bind msi_line_ctrl msi_line_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .snp_valid(snp_valid),
  .snp_cmd(snp_cmd), .flush_valid(flush_valid)
);

// File: tb/msi_line_ctrl_tb.sv
module msi_line_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [1:0]  cpu_op = 2'd0;
  logic [11:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready, cpu_done;
  logic [7:0]  cpu_rdata;
  logic        bus_req;
  logic [1:0]  bus_cmd;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_gnt = 1'b0;
  logic [7:0]  bus_rdata = '0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = 2'd0;
  logic [9:0]  snp_line = '0;
  logic        flush_valid;
  logic [7:0]  flush_data;

  always #10 clk = ~clk;

  msi_line_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_line(snp_line), .flush_valid(flush_valid),
    .flush_data(flush_data)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam logic [2:0] NO = 3'd4;
  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [7:0]  wd;
    logic [7:0]  g0;
    logic [7:0]  g1;
    logic [2:0]  c0;
    logic [2:0]  c1;
    logic [11:0] a0;
    logic [7:0]  wb;
    logic [7:0]  rd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{2'd0, 12'h104, 8'h00, 8'h11, 8'h00, 3'd0, NO,   12'h104, 8'h00, 8'h11}, // R1
    '{2'd0, 12'h104, 8'h00, 8'h00, 8'h00, NO,   NO,   12'h000, 8'h00, 8'h11}, // R4
    '{2'd1, 12'h104, 8'h22, 8'h00, 8'h00, 3'd2, NO,   12'h104, 8'h00, 8'h00}, // R3
    '{2'd0, 12'h104, 8'h00, 8'h00, 8'h00, NO,   NO,   12'h000, 8'h00, 8'h22}, // R4
    '{2'd1, 12'h104, 8'h33, 8'h00, 8'h00, NO,   NO,   12'h000, 8'h00, 8'h00}, // R4
    '{2'd1, 12'h108, 8'h44, 8'h00, 8'h00, 3'd1, NO,   12'h108, 8'h00, 8'h00}, // R2
    '{2'd0, 12'h108, 8'h00, 8'h00, 8'h00, NO,   NO,   12'h000, 8'h00, 8'h44}, // R2
    '{2'd0, 12'h204, 8'h00, 8'h00, 8'h55, 3'd3, 3'd0, 12'h104, 8'h33, 8'h55}, // R9
    '{2'd0, 12'h104, 8'h00, 8'h66, 8'h00, 3'd0, NO,   12'h104, 8'h00, 8'h66}, // R9
    '{2'd2, 12'h104, 8'h00, 8'h00, 8'h00, NO,   NO,   12'h000, 8'h00, 8'h00}, // R8
    '{2'd0, 12'h104, 8'h00, 8'h77, 8'h00, 3'd0, NO,   12'h104, 8'h00, 8'h77}, // R8
    '{2'd2, 12'h108, 8'h00, 8'h00, 8'h00, 3'd3, NO,   12'h108, 8'h44, 8'h00}, // R8
    '{2'd2, 12'h108, 8'h00, 8'h00, 8'h00, NO,   NO,   12'h000, 8'h00, 8'h00}  // R8
  };

  logic [2:0]  o_c0, o_c1;
  logic [11:0] o_a0;
  logic [7:0]  o_wb, o_rd;
  int          o_cyc;

  task automatic do_op(input logic [1:0] op, input logic [11:0] a,
                       input logic [7:0] wd, input logic [7:0] g0, input logic [7:0] g1);
    int n;
    n = 0; o_c0 = NO; o_c1 = NO; o_a0 = '0; o_wb = '0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = op; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    o_cyc = 1;
    while (!cpu_done && o_cyc < 50) begin
      bus_gnt = 1'b0;
      if (bus_req) begin
        if (n == 0) begin o_c0 = {1'b0, bus_cmd}; o_a0 = bus_addr; o_wb = bus_wdata; end
        else o_c1 = {1'b0, bus_cmd};
        bus_rdata = (n == 0) ? g0 : g1;
        bus_gnt = 1'b1;
        n++;
      end
      @(negedge clk);
      o_cyc++;
    end
    bus_gnt = 1'b0;
    o_rd = cpu_rdata;
  endtask

  task automatic do_snoop(input logic [1:0] c, input logic [11:0] a,
                          input logic exp_f, input logic [7:0] exp_d, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_line = a[11:2];
    @(negedge clk);
    snp_valid = 1'b0;
    chk({req, " flush_valid"}, int'(flush_valid), int'(exp_f));
    if (exp_f) chk({req, " flush_data"}, int'(flush_data), int'(exp_d));
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset cpu_ready", int'(cpu_ready), 1);
    chk("R12 reset bus_req", int'(bus_req), 0);
    chk("R12 reset flush_valid", int'(flush_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle cpu_done", int'(cpu_done), 0);

    for (int i = 0; i < NV; i++) begin
      do_op(VT[i].op, VT[i].addr, VT[i].wd, VT[i].g0, VT[i].g1);
      chk($sformatf("R1-table vec%0d first cmd (R2 R3 R8 R9)", i), int'(o_c0), int'(VT[i].c0));
      chk($sformatf("R9 vec%0d second cmd", i), int'(o_c1), int'(VT[i].c1));
      if (VT[i].c0 != NO) chk($sformatf("R1 vec%0d bus_addr", i), int'(o_a0), int'(VT[i].a0));
      if (VT[i].c0 == 3'd3) chk($sformatf("R8 vec%0d writeback data", i), int'(o_wb), int'(VT[i].wb));
      if (VT[i].op == 2'd0) chk($sformatf("R4 vec%0d rdata", i), int'(o_rd), int'(VT[i].rd));
      if (VT[i].c0 == NO) chk($sformatf("R4 vec%0d latency", i), o_cyc, 2);
    end

    // R6: dirty line snooped by BusRd flushes and drops to Shared
    do_op(2'd1, 12'h108, 8'h5A, 8'h00, 8'h00);
    chk("R2 write miss cmd", int'(o_c0), 1);
    do_snoop(2'd0, 12'h108, 1'b1, 8'h5A, "R6");
    do_op(2'd1, 12'h108, 8'h6B, 8'h00, 8'h00);
    chk("R6 line now Shared so write upgrades", int'(o_c0), 2);
    // R7: dirty line snooped by BusRdX flushes and invalidates
    do_snoop(2'd1, 12'h108, 1'b1, 8'h6B, "R7");
    do_op(2'd0, 12'h108, 8'h00, 8'h21, 8'h00);
    chk("R7 line now Invalid so read misses", int'(o_c0), 0);
    chk("R7 refill data", int'(o_rd), 8'h21);

    // R5: Shared line dropped silently on upgrade or read-exclusive
    do_snoop(2'd2, 12'h104, 1'b0, 8'h00, "R5 upgrade");
    do_op(2'd0, 12'h104, 8'h00, 8'h31, 8'h00);
    chk("R5 after upgrade snoop read misses", int'(o_c0), 0);
    do_snoop(2'd1, 12'h104, 1'b0, 8'h00, "R5 rdx");
    do_op(2'd0, 12'h104, 8'h00, 8'h32, 8'h00);
    chk("R5 after rdx snoop read misses", int'(o_c0), 0);

    // R11: snoops to other tag or invalid slot have no effect
    do_snoop(2'd1, 12'h204, 1'b0, 8'h00, "R11 other tag");
    do_snoop(2'd0, 12'h10C, 1'b0, 8'h00, "R11 invalid slot");
    do_op(2'd0, 12'h104, 8'h00, 8'h00, 8'h00);
    chk("R11 resident line still hits", int'(o_c0), int'(NO));
    chk("R11 resident data kept", int'(o_rd), 8'h32);

    // R10: pending upgrade held, snoop invalidates, request turns into BusRdX
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'd1; cpu_addr = 12'h104; cpu_wdata = 8'h99;
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R10 upgrade requested", int'(bus_req), 1);
    chk("R10 upgrade cmd", int'(bus_cmd), 2);
    chk("R10 not ready while waiting", int'(cpu_ready), 0);
    @(negedge clk);
    chk("R10 request held without grant", int'(bus_req), 1);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_line = 10'h041;
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R10 no flush from Shared", int'(flush_valid), 0);
    chk("R10 request re-evaluated", int'(bus_cmd), 1);
    bus_gnt = 1'b1; bus_rdata = 8'hEE;
    @(negedge clk);
    bus_gnt = 1'b0;
    chk("R10 done after grant", int'(cpu_done), 1);
    do_op(2'd0, 12'h104, 8'h00, 8'h00, 8'h00);
    chk("R10 line Modified after grant", int'(o_c0), int'(NO));
    chk("R10 written data", int'(o_rd), 8'h99);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule